// File: doc/BRIEF.md
# Platform Temperature Regulation Controller

This block holds down up to three board or skin temperatures by lowering a shared performance level. Each channel compares a temperature against a programmed target. The temperature is either the channel's sensor input or a value that software writes. On every update tick the channel moves its own 8-bit performance request. When the temperature is hot the request goes down, and when it is at or below target the request goes back up. The size of each step comes from a per-channel gain field. A per-channel floor limits how low the request may go.

The channels are configured through a simple memory-mapped register bus. Each channel has one 64-bit read/write word. Channel k sits at byte address `BASE_ADDR + 8*k`, and the default base is 0x5B20. The block outputs the lowest request among the enabled channels, which is the level a power-management actuator would apply. It also outputs each channel's own request and a per-channel flag that shows whether the channel is regulating downward.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After reset every channel word reads as zero, so every channel is disabled. Every channel request is 255, and `perf_level_o` is 255.
- R2: The channel word has these fields. Bits 7:0 hold the target temperature, in 0.5 °C units. Bit 8 enables the channel. Bits 11:9 hold the gain. Bit 12 selects the override temperature. Bits 23:16 hold the minimum performance level. Bits 31:24 hold the override temperature, in 0.5 °C units. A write takes effect at the clock edge that accepts it. A read returns the stored word on `bus_rdata_o` one cycle after the read request.
- R3: Bits 15:13 and 63:32 always read as zero. A read of an address that is not channel-aligned or lies beyond the last channel returns zero. A write to such an address changes no channel word.
- R4: On a tick, an enabled channel whose selected temperature is strictly greater than its target lowers its request by one step. The request does not go below the floor.
- R5: On a tick, an enabled channel whose selected temperature is less than or equal to its target raises its request by one step. The request saturates at 255.
- R6: The step size is 8 shifted right by the gain, with a minimum of 1. Gain 0 gives 8, gain 1 gives 4, gain 2 gives 2, and gains 3 to 7 give 1.
- R7: After any tick, an enabled channel's request is at least its minimum performance level. A floor of 255 therefore prevents all throttling.
- R8: When bit 12 is set, the channel regulates on bits 31:24 and ignores its sensor input. When bit 12 is clear, it regulates on the sensor input.
- R9: On a tick, a disabled channel's request is set to 255.
- R10: `perf_level_o` is the minimum request over the channels whose enable bit is currently set. It is 255 when no channel is enabled. `ch_hot_o[k]` is high when channel k is enabled and its selected temperature is above target.
- R11: Channel requests change only on a clock edge where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Regulation update strobe |
| sensor_temp_i | input | NUM_CH*8 | Sensor temperature per channel, 0.5 °C units, channel k at bits 8k+7:8k |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Read data, valid the cycle after a read request |
| perf_level_o | output | 8 | Combined performance level |
| ch_level_o | output | NUM_CH*8 | Per-channel performance request |
| ch_hot_o | output | NUM_CH | Per-channel hot flag |

## Verification
The assertions take for granted that a register write does not arrive on the same edge as a tick. Under that condition, the floor a channel was regulated against is the floor that is visible afterwards. They also assume that sensor inputs change only between ticks. The bench drives every bus access and tick from separate falling-edge tasks, one at a time. It never overlaps a write with a tick, and it changes sensor values only when no tick is pending.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int LVL_W = 8;
  localparam int TEMP_W = 8;
  localparam int WORD_W = 64;
  localparam logic [LVL_W-1:0] LVL_MAX = '1;
  // writable bits of a channel word
  localparam logic [WORD_W-1:0] CFG_WMASK = 64'h0000_0000_FFFF_1FFF;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [TEMP_W-1:0] temp_t;

  typedef struct packed {
    temp_t      ovr_temp;
    lvl_t       min_perf;
    logic       ovr_en;
    logic [2:0] gain;
    logic       enable;
    temp_t      target;
  } chan_cfg_t;

  function automatic lvl_t step_of(logic [2:0] gain);
    logic [3:0] s;
    s = 4'd8 >> gain;
    return (s == 4'd0) ? lvl_t'(1) : lvl_t'(s);
  endfunction
endpackage

// File: rtl/ptc_regbank.sv
module ptc_regbank
  import ptc_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h5B20,
  parameter int STRIDE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output chan_cfg_t         cfg_o [NUM_CH]
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int SH    = $clog2(STRIDE);
  localparam int SPAN  = NUM_CH * STRIDE;

  logic [ADDR_W-1:0] off;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] reg_q [NUM_CH];
  logic [WORD_W-1:0] rd_sel;

  assign off = addr_i - BASE_ADDR;
  assign hit = (off[SH-1:0] == '0) && (off < ADDR_W'(SPAN));
  assign idx = IDX_W'(off >> SH);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        reg_q[k] <= '0;
      else if (req_i && we_i && hit && (idx == IDX_W'(k)))
        reg_q[k] <= wdata_i & CFG_WMASK;
    end

    assign cfg_o[k].target   = reg_q[k][7:0];
    assign cfg_o[k].enable   = reg_q[k][8];
    assign cfg_o[k].gain     = reg_q[k][11:9];
    assign cfg_o[k].ovr_en   = reg_q[k][12];
    assign cfg_o[k].min_perf = reg_q[k][23:16];
    assign cfg_o[k].ovr_temp = reg_q[k][31:24];
  end

  always_comb begin
    rd_sel = '0;
    for (int k = 0; k < NUM_CH; k++)
      if (hit && (idx == IDX_W'(k))) rd_sel = reg_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_o <= '0;
    else if (req_i && !we_i)   rdata_o <= rd_sel;
  end
endmodule

// File: rtl/ptc_chan_loop.sv
module ptc_chan_loop
  import ptc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  chan_cfg_t cfg_i,
  input  temp_t     sensor_i,
  output lvl_t      level_o,
  output logic      hot_o
);
  temp_t          sel_temp;
  logic           hot;
  lvl_t           step;
  logic [LVL_W:0] sum;
  lvl_t           cand;
  lvl_t           nxt;
  lvl_t           level_q;

  assign sel_temp = cfg_i.ovr_en ? cfg_i.ovr_temp : sensor_i;
  assign hot      = sel_temp > cfg_i.target;
  assign hot_o    = cfg_i.enable && hot;
  assign step     = step_of(cfg_i.gain);
  assign sum      = {1'b0, level_q} + {1'b0, step};

  always_comb begin
    if (hot)
      cand = (level_q < step) ? '0 : level_q - step;
    else
      cand = sum[LVL_W] ? LVL_MAX : sum[LVL_W-1:0];
    // a raised floor pulls the request up immediately
    nxt = (cand < cfg_i.min_perf) ? cfg_i.min_perf : cand;
    if (!cfg_i.enable) nxt = LVL_MAX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     level_q <= LVL_MAX;
    else if (tick_i) level_q <= nxt;
  end

  assign level_o = level_q;
endmodule

// File: rtl/ptc_min_merge.sv
module ptc_min_merge
  import ptc_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [NUM_CH-1:0]       en_i,
  input  logic [NUM_CH*LVL_W-1:0] lvl_i,
  output lvl_t                    min_o
);
  always_comb begin
    min_o = LVL_MAX;
    for (int k = 0; k < NUM_CH; k++)
      if (en_i[k] && (lvl_i[k*LVL_W +: LVL_W] < min_o))
        min_o = lvl_i[k*LVL_W +: LVL_W];
  end
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
  import ptc_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h5B20,
  parameter int STRIDE = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic [NUM_CH*TEMP_W-1:0] sensor_temp_i,
  input  logic                     bus_req_i,
  input  logic                     bus_we_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [WORD_W-1:0]        bus_wdata_i,
  output logic [WORD_W-1:0]        bus_rdata_o,
  output logic [LVL_W-1:0]         perf_level_o,
  output logic [NUM_CH*LVL_W-1:0]  ch_level_o,
  output logic [NUM_CH-1:0]        ch_hot_o
);
  chan_cfg_t                cfg [NUM_CH];
  logic [NUM_CH-1:0]        cfg_en;
  logic [NUM_CH*LVL_W-1:0]  cfg_floor;

  ptc_regbank #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (bus_req_i),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o),
    .cfg_o  (cfg)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign cfg_en[k]                   = cfg[k].enable;
    assign cfg_floor[k*LVL_W +: LVL_W] = cfg[k].min_perf;

    ptc_chan_loop u_loop (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .cfg_i   (cfg[k]),
      .sensor_i(sensor_temp_i[k*TEMP_W +: TEMP_W]),
      .level_o (ch_level_o[k*LVL_W +: LVL_W]),
      .hot_o   (ch_hot_o[k])
    );
  end

  ptc_min_merge #(.NUM_CH(NUM_CH)) u_merge (
    .en_i (cfg_en),
    .lvl_i(ch_level_o),
    .min_o(perf_level_o)
  );
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker
  import ptc_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic [LVL_W-1:0]        perf_level_i,
  input logic [NUM_CH*LVL_W-1:0] ch_level_i,
  input logic [NUM_CH-1:0]       ch_hot_i,
  input logic [NUM_CH-1:0]       en_i,
  input logic [NUM_CH*LVL_W-1:0] floor_i
);
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(ch_level_i)); // R11

  AST_IDLE_OUT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> (perf_level_i == LVL_MAX)); // R10

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    AST_FLOOR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i && en_i[k] |=>
        ch_level_i[k*LVL_W +: LVL_W] >= $past(floor_i[k*LVL_W +: LVL_W])); // R7

    AST_DISABLED_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i && !en_i[k] |=> ch_level_i[k*LVL_W +: LVL_W] == LVL_MAX); // R9

    AST_OUT_NOT_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i[k] |-> perf_level_i <= ch_level_i[k*LVL_W +: LVL_W]); // R10

    AST_HOT_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i && ch_hot_i[k] |=>
        (ch_level_i[k*LVL_W +: LVL_W] <= $past(ch_level_i[k*LVL_W +: LVL_W])) ||
        (ch_level_i[k*LVL_W +: LVL_W] == $past(floor_i[k*LVL_W +: LVL_W]))); // R4

    AST_COOL_NO_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i && en_i[k] && !ch_hot_i[k] |=>
        ch_level_i[k*LVL_W +: LVL_W] >= $past(ch_level_i[k*LVL_W +: LVL_W])); // R5
  end
endmodule

bind thermal_throttle_ctrl ptc_checker #(.NUM_CH(NUM_CH)) u_ptc_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .perf_level_i(perf_level_o),
  .ch_level_i  (ch_level_o),
  .ch_hot_i    (ch_hot_o),
  .en_i        (cfg_en),
  .floor_i     (cfg_floor)
);

// File: tb/thermal_throttle_ctrl_tb.sv
module thermal_throttle_ctrl_tb;
  localparam int NCH = 3;
  localparam logic [15:0] A0 = 16'h5B20;
  localparam logic [15:0] A1 = 16'h5B28;
  localparam logic [15:0] A2 = 16'h5B30;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic [NCH*8-1:0]  sensor = '0;
  logic              req = 1'b0, we = 1'b0;
  logic [15:0]       addr = '0;
  logic [63:0]       wdata = '0;
  logic [63:0]       rdata;
  logic [7:0]        perf;
  logic [NCH*8-1:0]  lvl;
  logic [NCH-1:0]    hot;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  thermal_throttle_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sensor_temp_i(sensor),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .perf_level_o(perf), .ch_level_o(lvl), .ch_hot_o(hot)
  );

  // {cfg word[31:0], sensor, ticks, expected request}; start request 255
  localparam int NV = 11;
  localparam logic [55:0] VECS [NV] = '{
    {32'h0000_0164, 8'h78, 8'd3, 8'd231},  // gain0 step8 hot
    {32'h0000_0564, 8'h78, 8'd5, 8'd245},  // gain2 step2
    {32'h0000_0F64, 8'h78, 8'd4, 8'd251},  // gain7 step1
    {32'h0000_0964, 8'h78, 8'd3, 8'd252},  // gain4 step1
    {32'h00F0_0164, 8'h78, 8'd3, 8'd240},  // floor 240 clamps
    {32'h0000_0164, 8'h5A, 8'd2, 8'd255},  // cool saturates
    {32'hC800_1364, 8'h5A, 8'd2, 8'd247},  // override hot, sensor cool
    {32'h3200_1164, 8'hC8, 8'd2, 8'd255},  // override cool, sensor hot
    {32'h0000_0164, 8'h64, 8'd2, 8'd255},  // equal to target is cool
    {32'h00FF_0164, 8'h78, 8'd3, 8'd255},  // floor 255: no throttle
    {32'h0000_0764, 8'h78, 8'd2, 8'd253}   // gain3 step1
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [63:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    logic [63:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(perf == 8'hFF, "R1 perf after reset", perf, 8'hFF);
    chk(lvl == {NCH{8'hFF}}, "R1 levels after reset", lvl, {NCH{8'hFF}});
    bus_rd(A0, rd);
    chk(rd == 64'h0, "R1 word after reset", rd, 64'h0);

    // R2 R3 field storage and reserved bits
    bus_wr(A1, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_rd(A1, rd);
    chk(rd == 64'h0000_0000_FFFF_1FFF, "R3 reserved bits read zero", rd,
        64'h0000_0000_FFFF_1FFF);
    bus_wr(A2, 64'hABCD_0000_1234_5678);
    bus_rd(A2, rd);
    chk(rd == 64'h0000_0000_1234_1678, "R2 readback ch2", rd, 64'h0000_0000_1234_1678);

    // R3 unmapped accesses
    bus_wr(16'h5B38, 64'h0000_0000_1111_1111);
    bus_wr(16'h5B24, 64'h0000_0000_2222_2222);
    bus_rd(16'h5B38, rd);
    chk(rd == 64'h0, "R3 read past last channel", rd, 64'h0);
    bus_rd(16'h5B24, rd);
    chk(rd == 64'h0, "R3 misaligned read", rd, 64'h0);
    bus_rd(A0, rd);
    chk(rd == 64'h0, "R3 ch0 untouched by stray writes", rd, 64'h0);

    bus_wr(A1, 64'h0);
    bus_wr(A2, 64'h0);

    // R11 no movement without tick
    sensor[7:0] = 8'h78;
    bus_wr(A0, 64'h0000_0164);
    repeat (6) @(negedge clk);
    chk(lvl[7:0] == 8'hFF, "R11 request held without tick", lvl[7:0], 8'hFF);
    chk(hot[0] == 1'b1, "R10 hot flag when enabled and hot", hot[0], 1'b1);

    // R4 R5 R6 R7 R8 table
    for (int v = 0; v < NV; v++) begin
      bus_wr(A0, 64'h0);
      do_ticks(1);
      bus_wr(A0, {32'h0, VECS[v][55:24]});
      sensor[7:0] = VECS[v][23:16];
      do_ticks(int'(VECS[v][15:8]));
      chk(lvl[7:0] == VECS[v][7:0], $sformatf("R4 R5 R6 R7 R8 vector %0d level", v),
          lvl[7:0], VECS[v][7:0]);
      chk(perf == VECS[v][7:0], $sformatf("R10 vector %0d output", v), perf,
          VECS[v][7:0]);
    end

    // R10 R9 multi-channel merge
    bus_wr(A0, 64'h0);
    do_ticks(1);
    sensor = {8'h00, 8'h78, 8'h78};
    bus_wr(A0, 64'h0000_0164);  // step 8
    bus_wr(A1, 64'h0000_0364);  // step 4
    do_ticks(2);
    chk(lvl[15:0] == {8'd247, 8'd239}, "R6 two channel levels", lvl[15:0],
        {8'd247, 8'd239});
    chk(perf == 8'd239, "R10 min of two enabled", perf, 8'd239);
    bus_wr(A0, 64'h0000_0064);  // disable ch0
    @(negedge clk);
    chk(perf == 8'd247, "R10 disabled channel excluded", perf, 8'd247);
    chk(lvl[7:0] == 8'd239, "R11 disabled waits for tick", lvl[7:0], 8'd239);
    do_ticks(1);
    chk(lvl[7:0] == 8'hFF, "R9 disabled forced to 255", lvl[7:0], 8'hFF);
    chk(perf == 8'd243, "R10 remaining channel", perf, 8'd243);

    // R7 raised floor pulls request up on a hot tick
    bus_wr(A1, 64'h00FA_0364);
    do_ticks(1);
    chk(lvl[15:8] == 8'd250, "R7 raised floor applied", lvl[15:8], 8'd250);

    bus_wr(A1, 64'h0);
    @(negedge clk);
    chk(perf == 8'hFF, "R10 none enabled", perf, 8'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule